// File: doc/BRIEF.md
# Fracturable Lookup-Table Logic Element

This block is a configurable logic element with six data inputs, two outputs and one clock. A single mode bit chooses how it works. In whole mode the six inputs address one 64-entry truth table, and only output 0 carries a result. In split mode the element acts as two independent 5-input functions. Both read the same five low inputs, and each drives its own output.

Each of the two paths has a flip-flop that captures the path's lookup result on every rising clock edge. A per-path select bit chooses whether the output shows that flip-flop or the combinational lookup value. The truth table, the mode bit and the two select bits form one 67-bit configuration word. It is shifted in serially, most significant bit first, while a load-enable input is high.

Top module: `flut_element`

## Requirements
- R1: A synchronous active-high reset clears both path flip-flops and the whole configuration word to zero. After reset the element is in whole mode with combinational outputs and an all-zero table, so both outputs read 0.
- R2: In whole mode (mode bit 0), output 0 equals truth-table bit T[k], where k is the 6-bit input vector with input 0 as the least significant bit.
- R3: In whole mode, output 1 is 0 whatever the inputs, table or select bits are.
- R4: In split mode (mode bit 1), output 0 equals T[j] and output 1 equals T[32+j], where j is inputs 4..0 with input 0 as the least significant bit. Input 5 has no effect.
- R5: When a path's select bit is 1, its output shows the flip-flop, which holds the lookup value present at the previous rising edge. When the select bit is 0, the output follows the lookup value in the same cycle.
- R6: While the load enable is high, each rising edge shifts the serial bit into bit 0 of the configuration word and moves every other bit up one place. After 67 shifts the first bit sent sits in bit 66. Field positions: bit 66 is the mode (1 = split), bit 65 is the register select for output 1, bit 64 is the register select for output 0, and bits 63..0 hold T[63..0].
- R7: While the load enable is low, the serial input has no effect and the configuration word holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Element clock shared by all flip-flops |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_in | input | 1 | Serial configuration bit, MSB of the word first |
| data_i | input | 6 | Lookup inputs, bit 0 least significant |
| out_o | output | 2 | Path outputs |

## Verification
A combinational lookup result is due in the same cycle as its input. The bench therefore changes inputs on the falling edge and samples shortly afterwards, before the next rising edge. A registered result is due one rising edge after its input was applied, so the bench applies a vector, lets one rising edge pass and samples at the following falling edge. In the mixed-select case the bench also checks in the same sample that the combinational path already shows the new vector while the registered path still shows the previous one. A configuration word takes effect after its 67th shift edge, and every check is made only after the enable has been dropped.

// File: rtl/flut_pkg.sv
package flut_pkg;
   typedef enum logic {
      MODE_WHOLE = 1'b0,
      MODE_SPLIT = 1'b1
   } flut_mode_e;

   function automatic int unsigned table_bits(input int unsigned k);
      return 32'd1 << k;
   endfunction
endpackage

// File: rtl/flut_cfg_chain.sv
module flut_cfg_chain #(
   parameter int unsigned WORD_W = 67
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              shift_en,
   input  logic              ser_in,
   output logic [WORD_W-1:0] word
);
   if (WORD_W < 2) begin : g_bad_width
      $error("flut_cfg_chain: WORD_W must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (rst)
         word <= '0;
      else if (shift_en)
         word <= {word[WORD_W-2:0], ser_in};
   end

   assert_shift_entry_R6: assert property (@(posedge clk) disable iff (rst)
      shift_en |=> (word[0] == $past(ser_in)))
      else $error("serial bit not captured");

   assert_shift_move_R6: assert property (@(posedge clk) disable iff (rst)
      shift_en |=> (word[WORD_W-1:1] == $past(word[WORD_W-2:0])))
      else $error("chain did not advance");

   assert_hold_when_idle_R7: assert property (@(posedge clk) disable iff (rst)
      !shift_en |=> $stable(word))
      else $error("chain changed while idle");
endmodule

// File: rtl/flut_lut.sv
module flut_lut #(
   parameter int unsigned SEL_W    = 5,
   parameter bit          USE_TREE = 1'b1,
   localparam int unsigned DEPTH   = 1 << SEL_W
) (
   input  logic [DEPTH-1:0] tbl,
   input  logic [SEL_W-1:0] sel,
   output logic             y
);
   if (SEL_W < 1 || SEL_W > 12) begin : g_bad_sel
      $error("flut_lut: SEL_W out of range");
   end

   if (USE_TREE) begin : g_tree
      // heap-ordered mux tree: node i has children 2i and 2i+1, leaves at DEPTH..2*DEPTH-1
      logic [2*DEPTH-1:1] node;
      assign node[2*DEPTH-1:DEPTH] = tbl;
      for (genvar d = 0; d < SEL_W; d++) begin : g_lvl
         for (genvar n = 0; n < (1 << d); n++) begin : g_node
            localparam int unsigned IDX = (1 << d) + n;
            assign node[IDX] = sel[SEL_W-1-d] ? node[2*IDX+1] : node[2*IDX];
         end
      end
      assign y = node[1];
   end else begin : g_index
      assign y = tbl[sel];
   end
endmodule

// File: rtl/flut_path.sv
module flut_path (
   input  logic clk,
   input  logic rst,
   input  logic lut_val,
   input  logic use_reg,
   input  logic enable,
   output logic path_out
);
   logic cap_q;

   always_ff @(posedge clk) begin
      if (rst)
         cap_q <= 1'b0;
      else
         cap_q <= lut_val;
   end

   always_comb begin
      if (!enable)
         path_out = 1'b0;
      else if (use_reg)
         path_out = cap_q;
      else
         path_out = lut_val;
   end

   assert_capture_follows_lut_R5: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (cap_q == $past(lut_val)))
      else $error("flip-flop missed the lookup value");

   assert_registered_out_R5: assert property (@(posedge clk) disable iff (rst)
      (enable && use_reg && $past(!rst)) |-> (path_out == $past(lut_val)))
      else $error("registered output not one edge behind");
endmodule

// File: rtl/flut_element.sv
module flut_element
   import flut_pkg::*;
#(
   parameter int unsigned LUT_K    = 6,
   parameter bit          TREE_LUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cfg_en,
   input  logic             cfg_in,
   input  logic [LUT_K-1:0] data_i,
   output logic [1:0]       out_o
);
   localparam int unsigned TT_W   = table_bits(LUT_K);
   localparam int unsigned HALF_W = TT_W / 2;
   localparam int unsigned SUB_K  = LUT_K - 1;
   localparam int unsigned CFG_W  = TT_W + 3;

   if (LUT_K < 2 || LUT_K > 10) begin : g_bad_k
      $error("flut_element: LUT_K must lie in 2..10");
   end

   logic [CFG_W-1:0] cfg_word;
   logic [TT_W-1:0]  tt;
   logic [1:0]       reg_sel;
   flut_mode_e       mode;
   logic             split;
   logic             lo_val, hi_val, whole_val;
   logic             d0, d1;

   flut_cfg_chain #(.WORD_W(CFG_W)) u_chain (
      .clk     (clk),
      .rst     (rst),
      .shift_en(cfg_en),
      .ser_in  (cfg_in),
      .word    (cfg_word)
   );

   assign tt      = cfg_word[TT_W-1:0];
   assign reg_sel = cfg_word[TT_W+1:TT_W];
   assign mode    = flut_mode_e'(cfg_word[TT_W+2]);
   assign split   = (mode == MODE_SPLIT);

   flut_lut #(.SEL_W(SUB_K), .USE_TREE(TREE_LUT)) u_lut_lo (
      .tbl(tt[HALF_W-1:0]),
      .sel(data_i[SUB_K-1:0]),
      .y  (lo_val)
   );

   flut_lut #(.SEL_W(SUB_K), .USE_TREE(TREE_LUT)) u_lut_hi (
      .tbl(tt[TT_W-1:HALF_W]),
      .sel(data_i[SUB_K-1:0]),
      .y  (hi_val)
   );

   // the top input chooses between the halves to form the full-width function
   assign whole_val = data_i[LUT_K-1] ? hi_val : lo_val;
   assign d0        = split ? lo_val : whole_val;
   assign d1        = split & hi_val;

   flut_path u_path0 (
      .clk     (clk),
      .rst     (rst),
      .lut_val (d0),
      .use_reg (reg_sel[0]),
      .enable  (1'b1),
      .path_out(out_o[0])
   );

   flut_path u_path1 (
      .clk     (clk),
      .rst     (rst),
      .lut_val (d1),
      .use_reg (reg_sel[1]),
      .enable  (split),
      .path_out(out_o[1])
   );

   assert_whole_lookup_R2: assert property (@(posedge clk) disable iff (rst)
      (mode == MODE_WHOLE && !reg_sel[0]) |-> (out_o[0] == tt[data_i]))
      else $error("whole-mode lookup mismatch");

   assert_whole_out1_zero_R3: assert property (@(posedge clk) disable iff (rst)
      (mode == MODE_WHOLE) |-> (out_o[1] == 1'b0))
      else $error("output 1 active in whole mode");

   assert_split_hi_lookup_R4: assert property (@(posedge clk) disable iff (rst)
      (split && !reg_sel[1]) |-> (out_o[1] == tt[HALF_W + 32'(data_i[SUB_K-1:0])]))
      else $error("split upper lookup mismatch");

   assert_split_lo_lookup_R4: assert property (@(posedge clk) disable iff (rst)
      (split && !reg_sel[0]) |-> (out_o[0] == tt[data_i[SUB_K-1:0]]))
      else $error("split lower lookup mismatch");

   assert_reset_clears_R1: assert property (@(posedge clk)
      rst |=> (cfg_word == '0))
      else $error("reset left configuration set");
endmodule

// File: tb/tb_flut_element.sv
module tb_flut_element;
   localparam int CLK_P = 10;
   localparam logic [63:0] TT_A = 64'hA5C3_0F96_1E2D_7B48;
   localparam logic [63:0] TT_B = 64'h3C69_E1F0_8D27_5AB4;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       cfg_en = 1'b0;
   logic       cfg_in = 1'b0;
   logic [5:0] data_i = '0;
   logic [1:0] out_o;

   int n_total = 0;
   int n_fail  = 0;

   flut_element dut (
      .clk   (clk),
      .rst   (rst),
      .cfg_en(cfg_en),
      .cfg_in(cfg_in),
      .data_i(data_i),
      .out_o (out_o)
   );

   always #(CLK_P/2) clk = ~clk;

   task automatic chk(input string req, input logic act, input logic exp);
      n_total++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
      end
   endtask

   // expected combinational results from the requirements
   function automatic logic [1:0] model(input logic split, input logic [63:0] tt,
                                        input logic [5:0] d);
      if (split) return {tt[32 + int'(d[4:0])], tt[int'(d[4:0])]};
      else       return {1'b0, tt[int'(d)]};
   endfunction

   task automatic load_cfg(input logic split, input logic s1, input logic s0,
                           input logic [63:0] tt);
      logic [66:0] w;
      w = {split, s1, s0, tt};
      for (int i = 66; i >= 0; i--) begin
         @(negedge clk);
         cfg_en = 1'b1;
         cfg_in = w[i];
      end
      @(negedge clk);
      cfg_en = 1'b0;
      cfg_in = 1'b0;
   endtask

   task automatic t_reset_state();
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
      data_i = 6'd63;
      #1;
      chk("R1 out0 after reset", out_o[0], 1'b0);
      chk("R1 out1 after reset", out_o[1], 1'b0);
   endtask

   task automatic t_reset_clears_cfg();
      load_cfg(1'b0, 1'b1, 1'b1, {64{1'b1}});
      data_i = 6'd5;
      @(negedge clk);
      chk("R1 precondition registered one", out_o[0], 1'b1);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      #1;
      chk("R1 config cleared out0", out_o[0], 1'b0);
      chk("R1 config cleared out1", out_o[1], 1'b0);
   endtask

   task automatic t_whole_comb();
      logic [5:0] vecs [8] = '{6'd0, 6'd63, 6'd1, 6'd32, 6'd37, 6'd22, 6'd48, 6'd11};
      load_cfg(1'b0, 1'b0, 1'b0, TT_A);
      foreach (vecs[i]) begin
         @(negedge clk);
         data_i = vecs[i];
         #1;
         chk("R2 whole lookup", out_o[0], model(1'b0, TT_A, vecs[i])[0]);
         chk("R3 out1 zero comb", out_o[1], 1'b0);
      end
   endtask

   task automatic t_whole_reg_out1();
      load_cfg(1'b0, 1'b1, 1'b1, TT_B);
      for (int v = 40; v < 46; v++) begin
         @(negedge clk);
         data_i = 6'(v);
         @(negedge clk);
         chk("R3 out1 zero registered", out_o[1], 1'b0);
         chk("R5 whole registered out0", out_o[0], TT_B[v]);
      end
   endtask

   task automatic t_split_comb();
      load_cfg(1'b1, 1'b0, 1'b0, TT_B);
      for (int v = 0; v < 64; v += 7) begin
         logic [1:0] e;
         @(negedge clk);
         data_i = 6'(v);
         e = model(1'b1, TT_B, 6'(v));
         #1;
         chk("R4 split out0", out_o[0], e[0]);
         chk("R4 split out1", out_o[1], e[1]);
         // same low inputs with input 5 flipped must not change either output
         data_i[5] = ~data_i[5];
         #1;
         chk("R4 input5 ignored out0", out_o[0], e[0]);
         chk("R4 input5 ignored out1", out_o[1], e[1]);
      end
   endtask

   task automatic t_split_registered();
      logic [5:0] seq [5] = '{6'd3, 6'd17, 6'd30, 6'd9, 6'd24};
      logic [1:0] prev;
      load_cfg(1'b1, 1'b1, 1'b1, TT_A);
      foreach (seq[i]) begin
         @(negedge clk);
         data_i = seq[i];
         @(negedge clk);
         chk("R5 split registered out0", out_o[0], model(1'b1, TT_A, seq[i])[0]);
         chk("R5 split registered out1", out_o[1], model(1'b1, TT_A, seq[i])[1]);
      end
      // mixed: out0 registered, out1 combinational
      load_cfg(1'b1, 1'b0, 1'b1, TT_A);
      @(negedge clk);
      data_i = 6'd4;
      @(negedge clk);
      prev = model(1'b1, TT_A, 6'd4);
      data_i = 6'd27;
      #1;
      chk("R5 mixed comb out1 new", out_o[1], model(1'b1, TT_A, 6'd27)[1]);
      chk("R5 mixed reg out0 old", out_o[0], prev[0]);
      @(negedge clk);
      chk("R5 mixed reg out0 new", out_o[0], model(1'b1, TT_A, 6'd27)[0]);
   endtask

   task automatic t_idle_hold();
      load_cfg(1'b1, 1'b0, 1'b0, TT_A);
      for (int c = 0; c < 12; c++) begin
         @(negedge clk);
         cfg_in = ~cfg_in;
      end
      cfg_in = 1'b0;
      for (int v = 0; v < 32; v += 5) begin
         @(negedge clk);
         data_i = 6'(v);
         #1;
         chk("R7 idle out0 holds", out_o[0], model(1'b1, TT_A, 6'(v))[0]);
         chk("R7 idle out1 holds", out_o[1], model(1'b1, TT_A, 6'(v))[1]);
      end
   endtask

   task automatic t_shift_order();
      // a single one in the top bit sent first must end up as the mode bit (R6)
      load_cfg(1'b1, 1'b0, 1'b0, 64'h0000_0001_0000_0000);
      @(negedge clk);
      data_i = 6'd0;
      #1;
      chk("R6 mode bit from first shift", out_o[1], 1'b1);
      chk("R6 low half zero", out_o[0], 1'b0);
      load_cfg(1'b0, 1'b0, 1'b0, 64'h8000_0000_0000_0000);
      @(negedge clk);
      data_i = 6'd63;
      #1;
      chk("R6 table msb position", out_o[0], 1'b1);
      data_i = 6'd31;
      #1;
      chk("R6 table other entry", out_o[0], 1'b0);
   endtask

   initial begin
      #(CLK_P * 200000);
      n_total++;
      n_fail++;
      $display("FAIL watchdog R1..R7 run actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   end

   initial begin
      t_reset_state();
      t_whole_comb();
      t_whole_reg_out1();
      t_split_comb();
      t_split_registered();
      t_idle_hold();
      t_shift_order();
      t_reset_clears_cfg();
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   end
endmodule